// File: doc/BRIEF.md
# Rotate-and-Mask Shift Unit

A combinational execution unit for 64-bit integer shifts and rotates. An operation code picks one of seven result paths: left shift, right shift (logical or arithmetic with carry-out), word rotate with mask-and-insert, doubleword rotate with mask-and-insert, doubleword rotate with clear-left, doubleword rotate with clear-right, and sign-extend-word-then-shift-left. A 32-bit mode flag narrows the shift forms, and a signed flag turns the right shift into an arithmetic one.

The masked rotate forms share one wraparound mask generator. Bit positions count from the most significant bit, and a window whose start lies past its end wraps round the word. The 6-bit mask fields of the doubleword forms arrive with their lowest bit standing for the position's top bit, so the unit moves that bit up before use. An opaque context word and a small mux tag pass through unchanged, so a scheduler can route the result back to where it came from. The unit has no clock and no state, and its outputs follow its inputs in the same cycle.

Top module: `rms_unit`

## Requirements
- R1: `op_i` selects the result: 0 left shift, 1 right shift, 2 word rotate-insert, 3 doubleword rotate-insert, 4 rotate clear-left, 5 rotate clear-right, 6 sign-extend-then-shift-left. Code 7 gives result 0 and carry 0.
- R2: Mask position p (0 = most significant bit) is set when start ≤ p ≤ end if start ≤ end. If start > end it is set when p ≤ end or p ≥ start.
- R3: Left shift with `mode32_i`=1 shifts by `amt_i[5:0]` and keeps only result bits 31:0, with the upper 32 bits zero. With `mode32_i`=0 it shifts by `amt_i[6:0]`, so an amount of 64 or more gives 0.
- R4: Right shift with `mode32_i`=1 works on `src_i[31:0]`, sign-extended when `signed_i`=1 and zero-extended otherwise, by `amt_i[5:0]`, giving a 64-bit result. With `mode32_i`=0 it works on the full word by `amt_i[6:0]`. Amounts of 64 or more give all sign bits when signed and 0 when unsigned.
- R5: The carry is 1 only for a signed right shift of a negative value that shifts out at least one 1 bit. `carry_o` carries it in both bits. Every other operation gives `carry_o`=0.
- R6: Word rotate copies `src_i[31:0]` into both halves, rotates left by `amt_i[4:0]`, and uses mask start 32+`mb_i[4:0]` and end 32+`me_i[4:0]`. The result is (rotated & mask) | (`ins_i` & ~mask).
- R7: Doubleword rotate-insert rotates `src_i` left by `amt_i[5:0]`. The mask start is {`mb_i[0]`,`mb_i[5:1]`} and the end is 63−`amt_i[5:0]`. The result is (rotated & mask) | (`ins_i` & ~mask).
- R8: Clear-left rotates `src_i` left by `amt_i[5:0]` and ANDs with the mask from start {`mb_i[0]`,`mb_i[5:1]`} to end 63.
- R9: Clear-right rotates `src_i` left by `amt_i[5:0]` and ANDs with the mask from start 0 to end {`me_i[0]`,`me_i[5:1]`}.
- R10: Sign-extend-then-shift sign-extends `src_i[31:0]` to 64 bits and shifts it left by `amt_i[5:0]`.
- R11: `ctx_o` equals `ctx_i` and `tag_o` equals `tag_i` for every operation.
- R12: For clear-left and clear-right, `ins_i` has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_i | input | 64 | Source operand |
| ins_i | input | 64 | Insert operand for the rotate-insert forms |
| amt_i | input | 7 | Shift or rotate amount |
| mb_i | input | 6 | Mask start field |
| me_i | input | 6 | Mask end field |
| op_i | input | 3 | Operation code (see R1) |
| mode32_i | input | 1 | 32-bit mode for the shift forms |
| signed_i | input | 1 | Arithmetic right shift when 1 |
| ctx_i | input | 16 | Opaque operation context |
| tag_i | input | 2 | Mux tag |
| res_o | output | 64 | Result |
| carry_o | output | 2 | Carry, copied into both bits |
| ctx_o | output | 16 | Context passed through |
| tag_o | output | 2 | Mux tag passed through |

## Verification
The bench builds the unit with its default parameters: a 64-bit datapath, a 16-bit context and a 2-bit tag. At that width a 7-bit amount reaches 64 and above, so the over-range shift cases are exercised. The 6-bit mask fields reach every start and end position, including windows that wrap. Random operands are mixed with the amounts 0, 31, 32, 63 and 64 for every operation code, and the results are compared with a reference model built from the requirements.

// File: rtl/rms_pkg.sv
package rms_pkg;
    typedef enum logic [2:0] {
        RMS_SHL       = 3'd0,
        RMS_SHR       = 3'd1,
        RMS_ROT32     = 3'd2,
        RMS_ROT64_INS = 3'd3,
        RMS_ROT_CLRL  = 3'd4,
        RMS_ROT_CLRR  = 3'd5,
        RMS_EXTSL     = 3'd6,
        RMS_NONE      = 3'd7
    } rms_op_e;
endpackage

// File: rtl/rms_mask_gen.sv
module rms_mask_gen #(
    parameter int DATA_W = 64,
    parameter int POS_W  = $clog2(DATA_W)
) (
    input  logic [POS_W-1:0]  beg_i,
    input  logic [POS_W-1:0]  end_i,
    output logic [DATA_W-1:0] mask_o
);
    logic wrap;
    assign wrap = beg_i > end_i;

    // Position counts from the MSB: bit index g holds position DATA_W-1-g.
    for (genvar g = 0; g < DATA_W; g++) begin : g_bit
        localparam logic [POS_W-1:0] POS = POS_W'(DATA_W - 1 - g);
        logic past_beg, before_end;
        assign past_beg   = POS >= beg_i;
        assign before_end = POS <= end_i;
        assign mask_o[g]  = wrap ? (past_beg | before_end) : (past_beg & before_end);
    end

    always_comb begin
        if (beg_i == end_i) begin
            AST_MASK_SINGLE: assert ($countones(mask_o) == 1) else $error("single-position mask wrong"); // R2
        end
        if (beg_i == end_i + {{(POS_W-1){1'b0}}, 1'b1}) begin
            AST_MASK_FULL_WRAP: assert (&mask_o) else $error("adjacent wrap mask not full"); // R2
        end
    end
endmodule

// File: rtl/rms_rotl.sv
module rms_rotl #(
    parameter int DATA_W = 64,
    parameter int POS_W  = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] data_i,
    input  logic [POS_W-1:0]  amt_i,
    output logic [DATA_W-1:0] data_o
);
    logic [2*DATA_W-1:0] dbl;
    assign dbl    = {data_i, data_i} << amt_i;
    assign data_o = dbl[2*DATA_W-1:DATA_W];
endmodule

// File: rtl/rms_shifter.sv
module rms_shifter #(
    parameter int DATA_W = 64,
    parameter int POS_W  = $clog2(DATA_W),
    parameter int AMT_W  = POS_W + 1
) (
    input  logic [DATA_W-1:0] src_i,
    input  logic [AMT_W-1:0]  amt_i,
    input  logic              mode32_i,
    input  logic              signed_i,
    output logic [DATA_W-1:0] shl_o,
    output logic [DATA_W-1:0] shr_o,
    output logic [DATA_W-1:0] sxl_o,
    output logic              carry_o
);
    localparam int HALF_W = DATA_W / 2;

    logic [POS_W-1:0]         sh;
    logic [DATA_W-1:0]        shl_full;
    logic [DATA_W-1:0]        shr_in;
    logic                     shr_sign;
    logic                     over_range;
    logic                     lost_one;
    logic signed [DATA_W:0]   shr_wide;
    logic [DATA_W-1:0]        lost_mask;

    assign sh       = amt_i[POS_W-1:0];
    assign shl_full = src_i << sh;

    always_comb begin
        if (mode32_i) begin
            shl_o = {{HALF_W{1'b0}}, shl_full[HALF_W-1:0]};
        end else begin
            shl_o = amt_i[AMT_W-1] ? '0 : shl_full;
        end
    end

    always_comb begin
        if (mode32_i) begin
            shr_in     = {{HALF_W{signed_i & src_i[HALF_W-1]}}, src_i[HALF_W-1:0]};
            over_range = 1'b0;
        end else begin
            shr_in     = src_i;
            over_range = amt_i[AMT_W-1];
        end
        shr_sign  = signed_i & shr_in[DATA_W-1];
        shr_wide  = $signed({shr_sign, shr_in}) >>> sh;
        lost_mask = ~({DATA_W{1'b1}} << sh);
        if (over_range) begin
            shr_o    = {DATA_W{shr_sign}};
            lost_one = |shr_in;
        end else begin
            shr_o    = shr_wide[DATA_W-1:0];
            lost_one = |(shr_in & lost_mask);
        end
        carry_o = shr_sign & lost_one;
    end

    assign sxl_o = {{HALF_W{src_i[HALF_W-1]}}, src_i[HALF_W-1:0]} << sh;

    always_comb begin
        if (mode32_i) begin
            AST_SHL32_UPPER_ZERO: assert (shl_o[DATA_W-1:HALF_W] == '0) else $error("32-bit shift upper half"); // R3
        end
        if (!mode32_i && amt_i[AMT_W-1]) begin
            AST_SHL64_OVER: assert (shl_o == '0) else $error("over-range left shift nonzero"); // R3
        end
        if (!signed_i) begin
            AST_SHR_UNSIGNED_NO_CARRY: assert (!carry_o) else $error("logical shift carry"); // R5
        end
        if (sh == '0 && !over_range) begin
            AST_SHR_ZERO_AMT: assert (shr_o == shr_in && !carry_o) else $error("zero-amount right shift"); // R4
        end
    end
endmodule

// File: rtl/rms_unit.sv
module rms_unit #(
    parameter int DATA_W = 64,
    parameter int CTX_W  = 16,
    parameter int TAG_W  = 2
) (
    input  logic [DATA_W-1:0]          src_i,
    input  logic [DATA_W-1:0]          ins_i,
    input  logic [$clog2(DATA_W):0]    amt_i,
    input  logic [$clog2(DATA_W)-1:0]  mb_i,
    input  logic [$clog2(DATA_W)-1:0]  me_i,
    input  logic [2:0]                 op_i,
    input  logic                       mode32_i,
    input  logic                       signed_i,
    input  logic [CTX_W-1:0]           ctx_i,
    input  logic [TAG_W-1:0]           tag_i,
    output logic [DATA_W-1:0]          res_o,
    output logic [1:0]                 carry_o,
    output logic [CTX_W-1:0]           ctx_o,
    output logic [TAG_W-1:0]           tag_o
);
    import rms_pkg::*;

    localparam int POS_W  = $clog2(DATA_W);
    localparam int AMT_W  = POS_W + 1;
    localparam int HALF_W = DATA_W / 2;

    rms_op_e op;
    assign op = rms_op_e'(op_i);

    logic [POS_W-1:0] mb_swz, me_swz;
    assign mb_swz = {mb_i[0], mb_i[POS_W-1:1]};
    assign me_swz = {me_i[0], me_i[POS_W-1:1]};

    // Shift paths
    logic [DATA_W-1:0] shl_res, shr_res, sxl_res;
    logic              shr_carry;

    rms_shifter #(.DATA_W(DATA_W), .POS_W(POS_W), .AMT_W(AMT_W)) u_shifter (
        .src_i    (src_i),
        .amt_i    (amt_i),
        .mode32_i (mode32_i),
        .signed_i (signed_i),
        .shl_o    (shl_res),
        .shr_o    (shr_res),
        .sxl_o    (sxl_res),
        .carry_o  (shr_carry)
    );

    // Rotate path: word form duplicates the low half
    logic [DATA_W-1:0] rot_in, rot_out;
    logic [POS_W-1:0]  rot_amt;

    always_comb begin
        if (op == RMS_ROT32) begin
            rot_in  = {src_i[HALF_W-1:0], src_i[HALF_W-1:0]};
            rot_amt = {1'b0, amt_i[POS_W-2:0]};
        end else begin
            rot_in  = src_i;
            rot_amt = amt_i[POS_W-1:0];
        end
    end

    rms_rotl #(.DATA_W(DATA_W), .POS_W(POS_W)) u_rotl (
        .data_i (rot_in),
        .amt_i  (rot_amt),
        .data_o (rot_out)
    );

    // Mask window selection
    logic [POS_W-1:0]  win_beg, win_end;
    logic [DATA_W-1:0] mask;

    always_comb begin
        unique case (op)
            RMS_ROT32: begin
                win_beg = {1'b1, mb_i[POS_W-2:0]};
                win_end = {1'b1, me_i[POS_W-2:0]};
            end
            RMS_ROT64_INS: begin
                win_beg = mb_swz;
                win_end = ~amt_i[POS_W-1:0];
            end
            RMS_ROT_CLRL: begin
                win_beg = mb_swz;
                win_end = '1;
            end
            RMS_ROT_CLRR: begin
                win_beg = '0;
                win_end = me_swz;
            end
            default: begin
                win_beg = '0;
                win_end = '1;
            end
        endcase
    end

    rms_mask_gen #(.DATA_W(DATA_W), .POS_W(POS_W)) u_mask (
        .beg_i  (win_beg),
        .end_i  (win_end),
        .mask_o (mask)
    );

    logic [DATA_W-1:0] merged, cleared;
    assign merged  = (rot_out & mask) | (ins_i & ~mask);
    assign cleared = rot_out & mask;

    // Result select
    always_comb begin
        res_o   = '0;
        carry_o = 2'b00;
        unique case (op)
            RMS_SHL:       res_o = shl_res;
            RMS_SHR: begin
                res_o   = shr_res;
                carry_o = {2{shr_carry}};
            end
            RMS_ROT32,
            RMS_ROT64_INS: res_o = merged;
            RMS_ROT_CLRL,
            RMS_ROT_CLRR:  res_o = cleared;
            RMS_EXTSL:     res_o = sxl_res;
            RMS_NONE:      res_o = '0;
            default:       res_o = '0;
        endcase
    end

    assign ctx_o = ctx_i;
    assign tag_o = tag_i;

    always_comb begin
        AST_CARRY_PAIR: assert (carry_o[0] == carry_o[1]) else $error("carry bits differ"); // R5
        if (carry_o[0]) begin
            AST_CARRY_SOURCE: assert (op == RMS_SHR && signed_i) else $error("carry outside signed right shift"); // R5
        end
        if (op == RMS_ROT_CLRL || op == RMS_ROT_CLRR) begin
            AST_CLEAR_OUTSIDE_MASK: assert ((res_o & ~mask) == '0) else $error("clear form leaked bits"); // R12
        end
        if (op == RMS_ROT32 && mb_i[POS_W-2:0] == '0 && me_i[POS_W-2:0] == '1) begin
            AST_ROT32_UPPER_KEEP: assert (res_o[DATA_W-1:HALF_W] == ins_i[DATA_W-1:HALF_W]) else $error("word rotate upper half"); // R6
        end
    end
endmodule

// File: tb/rms_unit_bench.sv
module rms_unit_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 50000;
    localparam int DW = 64;
    localparam int CW = 16;
    localparam int TW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [DW-1:0] src, ins, res;
    logic [6:0]    amt;
    logic [5:0]    mb, me;
    logic [2:0]    op;
    logic          m32, sg;
    logic [CW-1:0] ctx, ctx_q;
    logic [TW-1:0] tag, tag_q;
    logic [1:0]    carry;

    rms_unit u_rms_unit (
        .src_i(src), .ins_i(ins), .amt_i(amt), .mb_i(mb), .me_i(me),
        .op_i(op), .mode32_i(m32), .signed_i(sg), .ctx_i(ctx), .tag_i(tag),
        .res_o(res), .carry_o(carry), .ctx_o(ctx_q), .tag_o(tag_q)
    );

    typedef struct {
        logic [DW-1:0] res;
        logic [1:0]    carry;
        logic [CW-1:0] ctx;
        logic [TW-1:0] tag;
        string         req;
    } item_t;

    item_t sb_q[$];
    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    function automatic logic [63:0] ref_mask(int b, int e);
        logic [63:0] m = '0;
        for (int p = 0; p < 64; p++) begin
            bit hit = (b <= e) ? (p >= b && p <= e) : (p >= b || p <= e);
            if (hit) m[63-p] = 1'b1;
        end
        return m;
    endfunction

    function automatic logic [63:0] ref_rot(logic [63:0] v, int a);
        logic [63:0] r;
        for (int i = 0; i < 64; i++) r[(i + a) % 64] = v[i];
        return r;
    endfunction

    function automatic int swz(logic [5:0] f);
        return int'({f[0], f[5:1]});
    endfunction

    task automatic ref_model(input logic [2:0] o, input logic w32, input logic s,
                             input logic [63:0] a, input logic [63:0] i,
                             input logic [6:0] n, input logic [5:0] b, input logic [5:0] e,
                             output logic [63:0] r, output logic [1:0] c);
        logic signed [127:0] x, y;
        logic [63:0] m, t;
        int k;
        r = '0; c = 2'b00;
        case (o)
            3'd0: begin
                if (w32) begin t = a << n[5:0]; r = {32'd0, t[31:0]}; end
                else r = (n >= 7'd64) ? 64'd0 : a << n;
            end
            3'd1: begin
                if (w32) x = s ? {{96{a[31]}}, a[31:0]} : {96'd0, a[31:0]};
                else     x = s ? {{64{a[63]}}, a} : {64'd0, a};
                k = w32 ? int'(n[5:0]) : int'(n);
                y = x >>> k;
                r = y[63:0];
                if (s && x < 0 && ((y <<< k) != x)) c = 2'b11;
            end
            3'd2: begin
                t = ref_rot({a[31:0], a[31:0]}, int'(n[4:0]));
                m = ref_mask(int'(b[4:0]) + 32, int'(e[4:0]) + 32);
                r = (t & m) | (i & ~m);
            end
            3'd3: begin
                t = ref_rot(a, int'(n[5:0]));
                m = ref_mask(swz(b), 63 - int'(n[5:0]));
                r = (t & m) | (i & ~m);
            end
            3'd4: r = ref_rot(a, int'(n[5:0])) & ref_mask(swz(b), 63);
            3'd5: r = ref_rot(a, int'(n[5:0])) & ref_mask(0, swz(e));
            3'd6: r = {{32{a[31]}}, a[31:0]} << n[5:0];
            default: r = '0;
        endcase
    endtask

    task automatic drive(input logic [2:0] o, input logic w32, input logic s,
                         input logic [63:0] a, input logic [63:0] i,
                         input logic [6:0] n, input logic [5:0] b, input logic [5:0] e,
                         input string req);
        item_t it;
        logic [63:0] r;
        logic [1:0] c;
        @(posedge clk);
        op = o; m32 = w32; sg = s; src = a; ins = i; amt = n; mb = b; me = e;
        ctx = CW'($urandom); tag = TW'($urandom);
        ref_model(o, w32, s, a, i, n, b, e, r, c);
        it.res = r; it.carry = c; it.ctx = ctx; it.tag = tag;
        it.req = $sformatf("%s R11", req);
        sb_q.push_back(it);
    endtask

    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            n_chk++;
            if (res !== it.res || carry !== it.carry || ctx_q !== it.ctx || tag_q !== it.tag) begin
                n_fail++;
                $display("FAIL %s op=%0d res=%h exp=%h carry=%b exp=%b ctx=%h exp=%h tag=%h exp=%h",
                         it.req, op, res, it.res, carry, it.carry, ctx_q, it.ctx, tag_q, it.tag);
            end
        end
    end

    function automatic logic [6:0] pick_amt();
        int sel = int'($urandom % 7);
        case (sel)
            0: return 7'd0;
            1: return 7'd31;
            2: return 7'd32;
            3: return 7'd63;
            4: return 7'd64;
            default: return 7'($urandom);
        endcase
    endfunction

    function automatic string op_req(int o);
        case (o)
            0: return "R3";
            1: return "R4 R5";
            2: return "R6";
            3: return "R7";
            4: return "R8";
            5: return "R9";
            6: return "R10";
            default: return "R1";
        endcase
    endfunction

    initial begin
        op = 3'd7; m32 = 0; sg = 0; src = '0; ins = '0; amt = '0; mb = '0; me = '0;
        ctx = '0; tag = '0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // R1: idle code after reset gives zero result and carry
        drive(3'd7, 0, 0, 64'd0, 64'd0, 7'd0, 6'd0, 6'd0, "R1");
        drive(3'd7, 0, 1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1234, 7'd5, 6'd3, 6'd9, "R1");
        // R3 boundaries
        drive(3'd0, 1, 0, 64'hFFFF_FFFF_FFFF_FFFF, 0, 7'd32, 0, 0, "R3");
        drive(3'd0, 1, 0, 64'h0000_0000_8000_0001, 0, 7'd31, 0, 0, "R3");
        drive(3'd0, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 0, 7'd64, 0, 0, "R3");
        drive(3'd0, 0, 0, 64'h0000_0000_0000_0001, 0, 7'd63, 0, 0, "R3");
        // R4/R5 boundaries
        drive(3'd1, 0, 1, 64'h8000_0000_0000_0000, 0, 7'd64, 0, 0, "R4 R5");
        drive(3'd1, 0, 1, 64'h8000_0000_0000_0000, 0, 7'd63, 0, 0, "R4 R5");
        drive(3'd1, 0, 1, 64'h8000_0000_0000_0001, 0, 7'd1, 0, 0, "R4 R5");
        drive(3'd1, 0, 0, 64'h8000_0000_0000_0001, 0, 7'd1, 0, 0, "R4 R5");
        drive(3'd1, 1, 1, 64'h0000_0000_8000_0000, 0, 7'd32, 0, 0, "R4 R5");
        drive(3'd1, 1, 0, 64'hFFFF_FFFF_8000_0000, 0, 7'd31, 0, 0, "R4 R5");
        drive(3'd1, 0, 1, 64'hFFFF_FFFF_FFFF_FFF0, 0, 7'd4, 0, 0, "R4 R5");
        // R2: wrapping and single-position windows
        drive(3'd2, 1, 0, 64'h0000_0000_DEAD_BEEF, 64'h5555_5555_5555_5555, 7'd8, 6'd20, 6'd3, "R2 R6");
        drive(3'd2, 0, 0, 64'h0000_0000_DEAD_BEEF, 64'hAAAA_AAAA_AAAA_AAAA, 7'd0, 6'd7, 6'd7, "R2 R6");
        drive(3'd4, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 7'd0, 6'd1, 6'd0, "R2 R8");
        drive(3'd5, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 7'd0, 6'd0, 6'd1, "R2 R9");
        drive(3'd3, 0, 0, 64'h0123_4567_89AB_CDEF, 64'hFFFF_0000_FFFF_0000, 7'd12, 6'd7, 6'd0, "R2 R7");
        // R12: insert operand all ones must not leak into clear forms
        drive(3'd4, 0, 0, 64'h0123_4567_89AB_CDEF, 64'hFFFF_FFFF_FFFF_FFFF, 7'd17, 6'd9, 6'd0, "R12 R8");
        drive(3'd5, 0, 0, 64'h0123_4567_89AB_CDEF, 64'hFFFF_FFFF_FFFF_FFFF, 7'd40, 6'd0, 6'd22, "R12 R9");
        // R10 boundaries
        drive(3'd6, 0, 0, 64'h1234_5678_8000_0001, 0, 7'd63, 0, 0, "R10");
        drive(3'd6, 0, 0, 64'hFFFF_FFFF_7FFF_FFFF, 0, 7'd32, 0, 0, "R10");
        // Randomized sweep over every code
        for (int o = 0; o < 8; o++) begin
            for (int k = 0; k < 40; k++) begin
                logic [6:0] n;
                n = pick_amt();
                if (o == 3 || o == 4 || o == 5 || o == 6 || o == 2) n[6] = 1'b0;
                drive(3'(o), 1'($urandom), 1'($urandom), {$urandom, $urandom},
                      (o == 4 || o == 5) ? 64'hFFFF_FFFF_FFFF_FFFF : {$urandom, $urandom},
                      n, 6'($urandom), 6'($urandom), op_req(o));
            end
        end
        @(posedge clk);
        @(posedge clk);
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R1 act=running exp=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule